// File: doc/BRIEF.md
# Pixel Region Latency Buffer

This block collects hits from one region of sixteen pixels arranged 4x4 and keeps them until the trigger decision for their bunch crossing is known. Each pixel presents a hit flag and a 5-bit time-over-threshold charge. In any crossing where at least one pixel fires, the block claims one slot of a buffer that all sixteen pixels share. The slot receives the crossing timestamp, the 16-bit map of the pixels that fired, and their charges.

A free-running timestamp counter advances once per crossing clock. Each held slot is compared against it. When a slot is exactly `LATENCY` crossings old, it is either picked or dropped, depending on the trigger input in that cycle. With the trigger asserted, the slot is queued for the end-of-column interface. Without it, the slot is released. Queued events leave in trigger order on a valid/ready output. A slot stays occupied until its event has been accepted.

A hit that finds no free slot is lost and counted in a saturating overflow counter. With the default parameters (40 MHz crossings, 12.5 µs latency), `LATENCY` is 500 and timestamps are 9 bits wide. Trigger rates up to one per 40 crossings (1 MHz) are sustained, because at most one slot reaches the trigger age in any cycle.

Top module: `region_latency_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid_o` is 0 and `ovf_count_o` is 0. The timestamp counter restarts from 0 and adds 1 per clock, modulo 2^TS_W.
- R2: In a cycle where `hit_i` is nonzero and a slot is free, the lowest-numbered free slot stores the current timestamp, the map `hit_i`, and the charges. The charge of pixel p is taken from `tot_i[5p+4:5p]`, and bit p of the map belongs to pixel p. The charge field of any pixel whose map bit is 0 is stored as 0.
- R3: If `trig_i` is 1 in a cycle where a held slot's age (current timestamp minus stored timestamp, modulo 2^TS_W) equals `LATENCY`, that event is queued. It is offered on the output from the next cycle, with `out_ts_o` equal to its stored timestamp.
- R4: A held slot that reaches age `LATENCY` while `trig_i` is 0 is released, and its event never appears on the output.
- R5: A trigger in a cycle where no held slot has age `LATENCY` puts nothing on the output.
- R6: While `out_valid_o` is 1 and `out_ready_i` is 0, the output stays valid and its timestamp, map and charges are unchanged. The slot is released only in the cycle where valid and ready are both 1.
- R7: When several events are queued, they are offered in the order in which their triggers were accepted.
- R8: There are `DEPTH` (8) slots. A nonzero hit with all slots occupied is dropped, and `ovf_count_o` rises by 1. The counter stops at 2^OVF_W-1 (255).
- R9: A slot released in a cycle, by expiry or by handshake, is not available to a hit arriving in that same cycle. If the buffer was full, that hit is dropped.
- R10: Timestamps wrap. An event stored shortly before the counter wraps is still matched and reported correctly after the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hit_i | input | NPIX | Per-pixel hit flags of this crossing |
| tot_i | input | NPIX*TOT_W | Per-pixel charges, pixel p at bits [TOT_W*p +: TOT_W] |
| trig_i | input | 1 | Trigger for the crossing LATENCY cycles back |
| out_ready_i | input | 1 | End-of-column accepts the offered event |
| out_valid_o | output | 1 | An event is offered |
| out_ts_o | output | TS_W | Timestamp of the offered event |
| out_map_o | output | NPIX | Hit map of the offered event |
| out_tot_o | output | NPIX*TOT_W | Charges of the offered event, unhit pixels zero |
| ovf_count_o | output | OVF_W | Saturating count of hits lost to a full buffer |

## Verification
Two cases can fall in the same cycle. The first is a release, when a slot expires or a handshake frees it. The second is a new hit arriving while every slot is occupied. The bench provokes this by feeding a hit in every crossing for a long stretch without triggers. The buffer stays full, and each expiry lands on a cycle that carries a hit. The behavioural model frees the slot without handing it to that hit, so the hit counts as lost. The overflow counter and the later output stream are compared against the model on every clock. A second coincidence, a trigger match while the end of column stalls, is driven by holding ready low for long windows and checking the queue order as it drains.

// File: rtl/rlb_pkg.sv
package rlb_pkg;

    // Life cycle of one buffer slot.
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_HELD = 2'd1,
        SLOT_SENT = 2'd2
    } slot_state_e;

endpackage

// File: rtl/rlb_find_free.sv
module rlb_find_free #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     free_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    // Lowest set bit wins: scan from the top so the last hit is the lowest.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rlb_age_match.sv
module rlb_age_match #(
    parameter int DEPTH   = 8,
    parameter int TS_W    = 9,
    parameter int LATENCY = 500
) (
    input  logic [TS_W-1:0]             now_i,
    input  logic [DEPTH-1:0][TS_W-1:0]  ts_i,
    input  logic [DEPTH-1:0]            held_i,
    output logic [DEPTH-1:0]            due_o
);

    localparam logic [TS_W-1:0] AGE_DUE = TS_W'(LATENCY);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [TS_W-1:0] age;
        assign age      = now_i - ts_i[g];
        assign due_o[g] = held_i[g] && (age == AGE_DUE);
    end

endmodule

// File: rtl/rlb_idx_fifo.sv
module rlb_idx_fifo #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [IDX_W-1:0] push_idx_i,
    input  logic             pop_i,
    output logic [IDX_W-1:0] head_o,
    output logic             empty_o
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][IDX_W-1:0] mem;
        logic [PTR_W-1:0]            rd;
        logic [PTR_W-1:0]            wr;
        logic [CNT_W-1:0]            cnt;
    } fifo_t;

    fifo_t q, d;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d = q;
        if (push_i) begin
            d.mem[q.wr] = push_idx_i;
            d.wr        = bump(q.wr);
        end
        if (pop_i) begin
            d.rd = bump(q.rd);
        end
        if (push_i && !pop_i) begin
            d.cnt = q.cnt + CNT_W'(1);
        end else if (pop_i && !push_i) begin
            d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign head_o  = q.mem[q.rd];
    assign empty_o = (q.cnt == '0);

endmodule

// File: rtl/region_latency_buffer.sv
module region_latency_buffer
    import rlb_pkg::*;
#(
    parameter int NPIX    = 16,
    parameter int TOT_W   = 5,
    parameter int TS_W    = 9,
    parameter int LATENCY = 500,
    parameter int DEPTH   = 8,
    parameter int OVF_W   = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NPIX-1:0]       hit_i,
    input  logic [NPIX*TOT_W-1:0] tot_i,
    input  logic                  trig_i,
    input  logic                  out_ready_i,
    output logic                  out_valid_o,
    output logic [TS_W-1:0]       out_ts_o,
    output logic [NPIX-1:0]       out_map_o,
    output logic [NPIX*TOT_W-1:0] out_tot_o,
    output logic [OVF_W-1:0]      ovf_count_o
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CHG_W = NPIX * TOT_W;

    typedef struct packed {
        logic [TS_W-1:0]                now;
        logic [OVF_W-1:0]               ovf;
        slot_state_e [DEPTH-1:0]        st;
        logic [DEPTH-1:0][TS_W-1:0]     ts;
        logic [DEPTH-1:0][NPIX-1:0]     map;
        logic [DEPTH-1:0][CHG_W-1:0]    chg;
    } regs_t;

    regs_t q, d;

    logic [DEPTH-1:0] free_vec;
    logic [DEPTH-1:0] held_vec;
    logic [DEPTH-1:0] due_vec;
    logic             free_found;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] match_idx;
    logic             match_push;
    logic [IDX_W-1:0] head_idx;
    logic             fifo_empty;
    logic             handshake;
    logic [CHG_W-1:0] masked_chg;
    logic [TS_W-1:0]  now_q;

    for (genvar g = 0; g < DEPTH; g++) begin : g_state
        assign free_vec[g] = (q.st[g] == SLOT_FREE);
        assign held_vec[g] = (q.st[g] == SLOT_HELD);
    end

    rlb_find_free #(
        .N     (DEPTH),
        .IDX_W (IDX_W)
    ) u_free (
        .free_i  (free_vec),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    rlb_age_match #(
        .DEPTH   (DEPTH),
        .TS_W    (TS_W),
        .LATENCY (LATENCY)
    ) u_match (
        .now_i  (q.now),
        .ts_i   (q.ts),
        .held_i (held_vec),
        .due_o  (due_vec)
    );

    // Slot index of the (single) due slot.
    always_comb begin
        match_idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (due_vec[i]) begin
                match_idx = IDX_W'(i);
            end
        end
    end

    assign match_push = trig_i && (|due_vec);

    rlb_idx_fifo #(
        .DEPTH (DEPTH),
        .IDX_W (IDX_W)
    ) u_order (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (match_push),
        .push_idx_i (match_idx),
        .pop_i      (handshake),
        .head_o     (head_idx),
        .empty_o    (fifo_empty)
    );

    assign out_valid_o = !fifo_empty;
    assign handshake   = out_valid_o && out_ready_i;

    // Charges of pixels that did not fire are cleared before storage.
    always_comb begin
        for (int p = 0; p < NPIX; p++) begin
            masked_chg[p*TOT_W +: TOT_W] = tot_i[p*TOT_W +: TOT_W] & {TOT_W{hit_i[p]}};
        end
    end

    always_comb begin
        d     = q;
        d.now = q.now + TS_W'(1);

        if (handshake) begin
            d.st[head_idx] = SLOT_FREE;
        end

        for (int i = 0; i < DEPTH; i++) begin
            if (due_vec[i]) begin
                d.st[i] = trig_i ? SLOT_SENT : SLOT_FREE;
            end
        end

        // Allocation sees only slots that were already free at the edge.
        if (|hit_i) begin
            if (free_found) begin
                d.st[free_idx]  = SLOT_HELD;
                d.ts[free_idx]  = q.now;
                d.map[free_idx] = hit_i;
                d.chg[free_idx] = masked_chg;
            end else if (q.ovf != {OVF_W{1'b1}}) begin
                d.ovf = q.ovf + OVF_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign out_ts_o    = q.ts[head_idx];
    assign out_map_o   = q.map[head_idx];
    assign out_tot_o   = q.chg[head_idx];
    assign ovf_count_o = q.ovf;
    assign now_q       = q.now;

endmodule

// File: rtl/rlb_checker.sv
module rlb_checker #(
    parameter int NPIX    = 16,
    parameter int TOT_W   = 5,
    parameter int TS_W    = 9,
    parameter int LATENCY = 500,
    parameter int OVF_W   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  out_valid_o,
    input logic                  out_ready_i,
    input logic [TS_W-1:0]       out_ts_o,
    input logic [NPIX-1:0]       out_map_o,
    input logic [NPIX*TOT_W-1:0] out_tot_o,
    input logic [OVF_W-1:0]      ovf_count_o,
    input logic [TS_W-1:0]       now_i
);

    logic [NPIX*TOT_W-1:0] unhit_mask;

    always_comb begin
        for (int p = 0; p < NPIX; p++) begin
            unhit_mask[p*TOT_W +: TOT_W] = {TOT_W{~out_map_o[p]}};
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_ts_o)
                                           && $stable(out_map_o) && $stable(out_tot_o)));

    // R2
    map_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_map_o != '0));

    // R2
    unhit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> ((out_tot_o & unhit_mask) == '0));

    // R8
    ovf_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ovf_count_o == $past(ovf_count_o))
                  || (ovf_count_o == $past(ovf_count_o) + OVF_W'(1))));

    // R3
    first_offer_age_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !$past(out_valid_o)) |-> ((now_i - out_ts_o) == TS_W'(LATENCY + 1)));

endmodule

bind region_latency_buffer rlb_checker #(
    .NPIX    (NPIX),
    .TOT_W   (TOT_W),
    .TS_W    (TS_W),
    .LATENCY (LATENCY),
    .OVF_W   (OVF_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_ts_o    (out_ts_o),
    .out_map_o   (out_map_o),
    .out_tot_o   (out_tot_o),
    .ovf_count_o (ovf_count_o),
    .now_i       (now_q)
);

// File: tb/region_latency_buffer_tb.sv
`timescale 1ns/1ps
module region_latency_buffer_tb;

    localparam int NPIX = 16;
    localparam int TOT_W = 5;
    localparam int TS_W = 9;
    localparam int LAT = 500;
    localparam int DEPTH = 8;
    localparam int OVF_W = 8;
    localparam int TSMOD = 1 << TS_W;
    localparam int OVF_MAX = (1 << OVF_W) - 1;
    localparam int NCYC = 8500;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [NPIX-1:0]       hit_i = '0;
    logic [NPIX*TOT_W-1:0] tot_i = '0;
    logic                  trig_i = 1'b0;
    logic                  out_ready_i = 1'b0;
    logic                  out_valid_o;
    logic [TS_W-1:0]       out_ts_o;
    logic [NPIX-1:0]       out_map_o;
    logic [NPIX*TOT_W-1:0] out_tot_o;
    logic [OVF_W-1:0]      ovf_count_o;

    always #5 clk = ~clk;

    region_latency_buffer u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .hit_i       (hit_i),
        .tot_i       (tot_i),
        .trig_i      (trig_i),
        .out_ready_i (out_ready_i),
        .out_valid_o (out_valid_o),
        .out_ts_o    (out_ts_o),
        .out_map_o   (out_map_o),
        .out_tot_o   (out_tot_o),
        .ovf_count_o (ovf_count_o)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Behavioural reference: slot bookkeeping plus an ordered queue.
    int                    m_st [DEPTH];   // 0 empty, 1 waiting, 2 queued
    int                    m_ts [DEPTH];
    logic [NPIX-1:0]       m_map [DEPTH];
    logic [NPIX*TOT_W-1:0] m_chg [DEPTH];
    int                    m_q [$];
    int                    m_now;
    int                    m_ovf;

    int c_emit = 0, c_expire = 0, c_nomatch = 0, c_multi = 0, c_r9 = 0, c_wrap = 0;

    function automatic int age_of(input int i);
        return (m_now - m_ts[i] + TSMOD) % TSMOD;
    endfunction

    function automatic bit any_due();
        for (int i = 0; i < DEPTH; i++) begin
            if (m_st[i] == 1 && age_of(i) == LAT) return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) m_st[i] = 0;
            m_q.delete();
            m_now = 0;
            m_ovf = 0;
        end else begin
            int  slot;
            int  first_free;
            bit  released;
            logic [NPIX*TOT_W-1:0] mc;
            released = 1'b0;
            first_free = -1;
            for (int i = DEPTH - 1; i >= 0; i--) if (m_st[i] == 0) first_free = i;
            if (m_q.size() > 0 && out_ready_i) begin
                slot = m_q.pop_front();
                m_st[slot] = 0;
                released = 1'b1;
                c_emit++;
            end
            if (trig_i && !any_due()) c_nomatch++;
            for (int i = 0; i < DEPTH; i++) begin
                if (m_st[i] == 1 && age_of(i) == LAT) begin
                    if (trig_i) begin
                        m_st[i] = 2;
                        m_q.push_back(i);
                    end else begin
                        m_st[i] = 0;
                        released = 1'b1;
                        c_expire++;
                    end
                end
            end
            if (hit_i != '0) begin
                if (first_free >= 0) begin
                    for (int p = 0; p < NPIX; p++)
                        mc[p*TOT_W +: TOT_W] = hit_i[p] ? tot_i[p*TOT_W +: TOT_W] : '0;
                    m_st[first_free]  = 1;
                    m_ts[first_free]  = m_now;
                    m_map[first_free] = hit_i;
                    m_chg[first_free] = mc;
                end else begin
                    if (released) c_r9++;
                    if (m_ovf < OVF_MAX) m_ovf++;
                end
            end
            if (m_q.size() >= 2) c_multi++;
            m_now = (m_now + 1) % TSMOD;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        bit ev;
        ev = (m_q.size() > 0);
        chk(out_valid_o == ev, "R3 R4 R5", "out_valid", out_valid_o, ev);
        if (ev && out_valid_o) begin
            chk(out_ts_o == TS_W'(m_ts[m_q[0]]), "R3 R10", "out_ts", out_ts_o, m_ts[m_q[0]]);
            chk(out_map_o == m_map[m_q[0]], "R2 R7", "out_map", out_map_o, m_map[m_q[0]]);
            chk(out_tot_o == m_chg[m_q[0]], "R2 R6", "out_tot", out_tot_o, m_chg[m_q[0]]);
            if (m_ts[m_q[0]] > m_now) c_wrap++;
        end
        chk(ovf_count_o == OVF_W'(m_ovf), "R8 R9", "ovf_count", ovf_count_o, m_ovf);
    endtask

    int unsigned seed = 32'h1234_5679;
    function automatic int unsigned rnd();
        seed ^= seed << 13;
        seed ^= seed >> 17;
        seed ^= seed << 5;
        return seed;
    endfunction

    task automatic drive(input int cyc);
        int unsigned r;
        int unsigned h;
        r = rnd();
        h = rnd();
        tot_i = {rnd(), rnd(), rnd()};
        if (cyc < 4000) begin
            hit_i = (r % 64 == 0) ? h[NPIX-1:0] : '0;
            trig_i = any_due() ? 1'b1 : (rnd() % 40 == 0);
            out_ready_i = ((cyc / 200) % 3) != 0;
        end else if (cyc < 5500) begin
            hit_i = h[NPIX-1:0] | 16'h0001;
            trig_i = 1'b0;
            out_ready_i = 1'b1;
        end else begin
            hit_i = (r % 64 == 0) ? h[NPIX-1:0] : '0;
            trig_i = any_due() ? rnd() % 2 == 0 : (rnd() % 40 == 0);
            out_ready_i = rnd() % 2 == 0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (4) begin
            @(negedge clk);
            // R1: reset state
            chk(out_valid_o == 1'b0, "R1", "reset valid", out_valid_o, 0);
            chk(ovf_count_o == '0, "R1", "reset ovf", ovf_count_o, 0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first cycle after reset
        chk(out_valid_o == 1'b0, "R1", "post-reset valid", out_valid_o, 0);
        for (int cyc = 0; cyc < NCYC; cyc++) begin
            compare();
            drive(cyc);
            @(negedge clk);
        end
        compare();
        chk(c_emit > 0, "R3", "events delivered", c_emit, 1);
        chk(c_expire > 0, "R4", "events expired", c_expire, 1);
        chk(c_nomatch > 0, "R5", "unmatched triggers", c_nomatch, 1);
        chk(c_multi > 0, "R7", "queue depth two or more seen", c_multi, 1);
        chk(c_r9 > 0, "R9", "hit lost on release cycle", c_r9, 1);
        chk(c_wrap > 0, "R10", "wrapped timestamp delivered", c_wrap, 1);
        chk(ovf_count_o == OVF_W'(OVF_MAX), "R8", "overflow saturated", ovf_count_o, OVF_MAX);
        finish_run();
    end

endmodule